// File: doc/BRIEF.md
# Exact-Recency Victim Tracker

This block keeps the replacement order for every set of a set-associative cache. The cache controller reports each load or store that lands in a way through a touch port. The touched way becomes the newest in its set. When the controller needs a slot for a fill, it queries a set, and one cycle later it receives the way to replace. A way holding nothing is returned first. Among valid ways, the one used longest ago is returned. The order is exact: each way of a set carries an age rank, and the ranks always form a permutation of the way numbers.

The associativity in use is an input, `cfg_ways`, which may take any value from 1 up to the built-in maximum (64 by default). Ways at or above that count still keep their rank, but they are never offered as victims. A separate port marks one way of a set as empty, for example after a coherence invalidation. Tag comparison, data storage and random replacement belong to other blocks.

Top module: `lru_tracker`

## Requirements
- R1: After reset, no victim is reported until a query is made, and a query of any set returns way 0, because every way starts empty.
- R2: A touched way becomes valid and becomes the most recent way of its set. It is not returned as the victim while any other way in range is older.
- R3: When all ways in range are valid, the victim is the way that every other way in range was touched after.
- R4: If any way below `cfg_ways` is empty, the victim is the lowest-numbered empty way, whatever the recency order.
- R5: An invalidate of a way marks it empty, so that it becomes eligible as an empty way under R4.
- R6: Ways numbered `cfg_ways` or higher are never returned. A `cfg_ways` of 0 is treated as 1, and a value above the maximum is treated as the maximum.
- R7: With `cfg_ways` equal to 1, the victim is always way 0.
- R8: `victim_valid` is high in the cycle after `query_en`, and `victim_way` then holds the answer. That answer reflects the updates of earlier cycles and not a touch issued in the same cycle as the query.
- R9: If a touch and an invalidate arrive in the same cycle, the touch is applied and the invalidate is dropped.
- R10: Sets are independent. Touching or invalidating one set does not change the victim of another set.
- R11: The full 64-way order is kept exactly under arbitrary sequences of touches and invalidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; empties all sets |
| cfg_ways | input | 7 | Associativity in use (1..64) |
| touch_en | input | 1 | A way was read or written this cycle |
| touch_set | input | 9 | Set of the touch |
| touch_way | input | 6 | Way of the touch |
| inv_en | input | 1 | Mark one way empty |
| inv_set | input | 9 | Set of the invalidate |
| inv_way | input | 6 | Way of the invalidate |
| query_en | input | 1 | Request a victim |
| query_set | input | 9 | Set to pick a victim from |
| victim_valid | output | 1 | Victim answer present (one cycle after the query) |
| victim_way | output | 6 | Way to replace |

## Verification
The assertions assume that set indices stay below the number of sets and that `cfg_ways` does not change between a query and its answer. Under that assumption, the bound on the way returned, which is checked against the previous cycle's `cfg_ways`, is meaningful. They also assume that reset is applied before any traffic. The stimulus changes `cfg_ways` only while no query is in flight. It uses only legal set numbers, including the top one, and drives every input on the falling edge, so the one-cycle answer latency is sampled in a fixed cycle.

// File: rtl/lru_pkg.sv
package lru_pkg;

    // Which single update a set receives in a cycle.
    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,
        UPD_TOUCH = 2'd1,
        UPD_EMPTY = 2'd2
    } upd_kind_e;

    // A touch outranks an invalidate (the invalidate is dropped).
    function automatic upd_kind_e pick_update(input logic touch, input logic inval);
        if (touch)      return UPD_TOUCH;
        else if (inval) return UPD_EMPTY;
        else            return UPD_IDLE;
    endfunction

endpackage

// File: rtl/lru_age_update.sv
module lru_age_update #(
    parameter int MAX_WAYS = 64,
    parameter int WW       = 6
) (
    input  logic                          chk_en,
    input  logic [MAX_WAYS-1:0][WW-1:0]   age_in,
    input  logic [MAX_WAYS-1:0]           vld_in,
    input  logic [WW-1:0]                 way,
    output logic [MAX_WAYS-1:0][WW-1:0]   age_out,
    output logic [MAX_WAYS-1:0]           vld_out
);

    logic [WW-1:0]       old_age;
    logic [MAX_WAYS-1:0] is_newest;

    assign old_age = age_in[way];

    // Per-way rank rule: the touched way drops to 0, younger ways age by one.
    for (genvar g = 0; g < MAX_WAYS; g++) begin : g_way
        logic hit;
        assign hit        = (WW'(g) == way);
        assign age_out[g] = hit ? '0
                          : (age_in[g] < old_age) ? age_in[g] + 1'b1
                          : age_in[g];
        assign vld_out[g] = vld_in[g] | hit;
        assign is_newest[g] = (age_out[g] == '0);
    end

    // R3: ranks stay a permutation, so exactly one way is newest after a touch
    always_comb begin
        if (chk_en) begin
            a_r3_single_newest: assert ($countones(is_newest) == 1);
        end
    end

endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
    parameter int MAX_WAYS = 64,
    parameter int WW       = 6,
    parameter int CW       = 7
) (
    input  logic [MAX_WAYS-1:0][WW-1:0] age_in,
    input  logic [MAX_WAYS-1:0]         vld_in,
    input  logic [CW-1:0]               cfg_ways,
    output logic [WW-1:0]               way
);

    int            lim;
    logic          have_empty;
    logic          have_old;
    logic [WW-1:0] empty_way;
    logic [WW-1:0] old_way;
    logic [WW-1:0] old_age;

    always_comb begin
        lim = int'(cfg_ways);
        if (lim < 1)        lim = 1;
        if (lim > MAX_WAYS) lim = MAX_WAYS;
        have_empty = 1'b0;
        have_old   = 1'b0;
        empty_way  = '0;
        old_way    = '0;
        old_age    = '0;
        for (int i = 0; i < MAX_WAYS; i++) begin
            if (i < lim) begin
                if (!vld_in[i] && !have_empty) begin
                    have_empty = 1'b1;
                    empty_way  = WW'(i);
                end
                if (!have_old || age_in[i] > old_age) begin
                    have_old = 1'b1;
                    old_age  = age_in[i];
                    old_way  = WW'(i);
                end
            end
        end
        way = have_empty ? empty_way : old_way;
    end

endmodule

// File: rtl/lru_tracker.sv
module lru_tracker #(
    parameter int NUM_SETS = 512,
    parameter int MAX_WAYS = 64,
    localparam int SW = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WW = (MAX_WAYS > 1) ? $clog2(MAX_WAYS) : 1,
    localparam int CW = $clog2(MAX_WAYS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_ways,
    input  logic          touch_en,
    input  logic [SW-1:0] touch_set,
    input  logic [WW-1:0] touch_way,
    input  logic          inv_en,
    input  logic [SW-1:0] inv_set,
    input  logic [WW-1:0] inv_way,
    input  logic          query_en,
    input  logic [SW-1:0] query_set,
    output logic          victim_valid,
    output logic [WW-1:0] victim_way
);
    import lru_pkg::*;

    typedef logic [MAX_WAYS-1:0][WW-1:0] age_row_t;
    typedef logic [MAX_WAYS-1:0]         vld_row_t;

    typedef struct packed {
        logic [NUM_SETS-1:0] live;
        logic                vvalid;
        logic [WW-1:0]       vway;
    } state_t;

    typedef struct packed {
        logic          en;
        logic [SW-1:0] set;
        age_row_t      age;
        vld_row_t      vld;
    } wr_t;

    state_t    st_d, st_q;
    wr_t       wr_d;
    upd_kind_e kind;

    age_row_t age_mem [NUM_SETS];
    vld_row_t vld_mem [NUM_SETS];

    age_row_t      init_age;
    logic [SW-1:0] upd_set;
    age_row_t      upd_age, tch_age, q_age;
    vld_row_t      upd_vld, tch_vld, q_vld;
    logic [WW-1:0] pick_way;

    // A never-written set reads as all empty with ranks equal to way number.
    for (genvar g = 0; g < MAX_WAYS; g++) begin : g_init
        assign init_age[g] = WW'(g);
    end

    assign kind    = pick_update(touch_en, inv_en);
    assign upd_set = touch_en ? touch_set : inv_set;
    assign upd_age = st_q.live[upd_set] ? age_mem[upd_set] : init_age;
    assign upd_vld = st_q.live[upd_set] ? vld_mem[upd_set] : '0;
    assign q_age   = st_q.live[query_set] ? age_mem[query_set] : init_age;
    assign q_vld   = st_q.live[query_set] ? vld_mem[query_set] : '0;

    lru_age_update #(.MAX_WAYS(MAX_WAYS), .WW(WW)) u_update (
        .chk_en  (touch_en),
        .age_in  (upd_age),
        .vld_in  (upd_vld),
        .way     (touch_way),
        .age_out (tch_age),
        .vld_out (tch_vld)
    );

    lru_victim_pick #(.MAX_WAYS(MAX_WAYS), .WW(WW), .CW(CW)) u_pick (
        .age_in   (q_age),
        .vld_in   (q_vld),
        .cfg_ways (cfg_ways),
        .way      (pick_way)
    );

    always_comb begin
        st_d        = st_q;
        wr_d        = '0;
        wr_d.set    = upd_set;
        wr_d.age    = upd_age;
        wr_d.vld    = upd_vld;
        unique case (kind)
            UPD_TOUCH: begin
                wr_d.en  = 1'b1;
                wr_d.age = tch_age;
                wr_d.vld = tch_vld;
            end
            UPD_EMPTY: begin
                wr_d.en = 1'b1;
                wr_d.vld[inv_way] = 1'b0;
            end
            default: wr_d.en = 1'b0;
        endcase
        if (wr_d.en) st_d.live[upd_set] = 1'b1;
        st_d.vvalid = query_en;
        if (query_en) st_d.vway = pick_way;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_d.en) begin
            age_mem[wr_d.set] <= wr_d.age;
            vld_mem[wr_d.set] <= wr_d.vld;
        end
    end

    assign victim_valid = st_q.vvalid;
    assign victim_way   = st_q.vway;

    // R2: a touched way is stored as valid and newest
    a_r2_touched_newest: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> (age_mem[$past(touch_set)][$past(touch_way)] == '0) &&
                     vld_mem[$past(touch_set)][$past(touch_way)]);

    // R6: the returned way lies inside the configured associativity
    a_r6_victim_in_range: assert property (@(posedge clk) disable iff (rst)
        (victim_valid && $past(cfg_ways) != '0) |-> (CW'(victim_way) < $past(cfg_ways)));

    // R7: direct-mapped use always replaces way 0
    a_r7_direct_way0: assert property (@(posedge clk) disable iff (rst)
        (victim_valid && $past(cfg_ways) <= CW'(1)) |-> (victim_way == '0));

    // R8: an answer only ever follows a query
    a_r8_answer_follows_query: assert property (@(posedge clk) disable iff (rst)
        $rose(victim_valid) |-> $past(query_en));

endmodule

// File: tb/lru_tracker_tb.sv
module lru_tracker_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] cfg_ways;
    logic       touch_en, inv_en, query_en;
    logic [8:0] touch_set, inv_set, query_set;
    logic [5:0] touch_way, inv_way;
    logic       victim_valid;
    logic [5:0] victim_way;

    int n_tests = 0;
    int n_fail  = 0;

    // reference: last-touch time stamps and validity for 8 set slots
    int ref_ts  [8][64];
    bit ref_vld [8][64];
    int now_t = 0;

    always #4 clk = ~clk;

    lru_tracker u_dut (
        .clk(clk), .rst(rst), .cfg_ways(cfg_ways),
        .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way),
        .inv_en(inv_en), .inv_set(inv_set), .inv_way(inv_way),
        .query_en(query_en), .query_set(query_set),
        .victim_valid(victim_valid), .victim_way(victim_way)
    );

    function automatic int slot(int s);
        return s % 8;
    endfunction

    function automatic void ref_touch(int s, int w);
        now_t++;
        ref_ts[slot(s)][w]  = now_t;
        ref_vld[slot(s)][w] = 1'b1;
    endfunction

    function automatic int ref_victim(int s);
        int lim;
        int best;
        lim = int'(cfg_ways);
        if (lim < 1) lim = 1;
        if (lim > 64) lim = 64;
        for (int i = 0; i < lim; i++)
            if (!ref_vld[slot(s)][i]) return i;
        best = 0;
        for (int i = 1; i < lim; i++)
            if (ref_ts[slot(s)][i] < ref_ts[slot(s)][best]) best = i;
        return best;
    endfunction

    task automatic check(bit ok, string req, int got, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic touch(int s, int w);
        @(negedge clk);
        touch_en = 1'b1; touch_set = 9'(s); touch_way = 6'(w);
        @(negedge clk);
        touch_en = 1'b0;
        ref_touch(s, w);
    endtask

    task automatic inval(int s, int w);
        @(negedge clk);
        inv_en = 1'b1; inv_set = 9'(s); inv_way = 6'(w);
        @(negedge clk);
        inv_en = 1'b0;
        ref_vld[slot(s)][w] = 1'b0;
    endtask

    task automatic check_victim(int s, string req);
        int exp;
        @(negedge clk);
        query_en = 1'b1; query_set = 9'(s);
        @(negedge clk);
        query_en = 1'b0;
        exp = ref_victim(s);
        check(victim_valid && int'(victim_way) == exp, req, int'(victim_way), exp);
    endtask

    // R1: reset state
    task automatic t_reset();
        check(victim_valid == 1'b0, "R1 no answer before query", int'(victim_valid), 0);
        cfg_ways = 7'd4;
        check_victim(0, "R1 empty set 0");
        check_victim(511, "R1 empty set 511");
    endtask

    // R2 R3 R4: filling and recency order
    task automatic t_order();
        cfg_ways = 7'd4;
        touch(1, 0);
        check_victim(1, "R4 lowest empty way");
        touch(1, 1); touch(1, 2); touch(1, 3);
        check_victim(1, "R3 oldest after fill");
        touch(1, 0);
        check_victim(1, "R2 touched way not victim");
        touch(1, 2);
        touch(1, 1);
        check_victim(1, "R3 exact order");
        check(int'(victim_way) == 3, "R3 way 3 oldest", int'(victim_way), 3);
    endtask

    // R5: invalidate makes way eligible
    task automatic t_invalidate();
        cfg_ways = 7'd4;
        inval(1, 2);
        check_victim(1, "R5 invalidated way chosen");
        touch(1, 2);
        check_victim(1, "R5 refilled way");
    endtask

    // R6 R7: associativity limits
    task automatic t_range();
        cfg_ways = 7'd2;
        touch(2, 0); touch(2, 1); touch(2, 3);
        check_victim(2, "R6 out-of-range way ignored");
        touch(2, 0);
        check_victim(2, "R6 in-range order");
        cfg_ways = 7'd0;
        check_victim(2, "R6 zero treated as one");
        cfg_ways = 7'd1;
        touch(2, 0);
        check_victim(2, "R7 direct mapped way 0");
        cfg_ways = 7'd100;
        check_victim(2, "R6 above maximum clamps");
    endtask

    // R8: query sees state before a same-cycle touch
    task automatic t_same_cycle();
        int exp;
        cfg_ways = 7'd4;
        @(negedge clk);
        touch_en = 1'b1; touch_set = 9'd3; touch_way = 6'd0;
        query_en = 1'b1; query_set = 9'd3;
        exp = ref_victim(3);
        @(negedge clk);
        touch_en = 1'b0; query_en = 1'b0;
        check(victim_valid && int'(victim_way) == exp, "R8 same-cycle touch unseen",
              int'(victim_way), exp);
        ref_touch(3, 0);
        check_victim(3, "R8 touch seen next query");
        @(negedge clk);
        check(victim_valid == 1'b0, "R8 answer lasts one cycle", int'(victim_valid), 0);
    endtask

    // R9: touch wins over invalidate
    task automatic t_collision();
        cfg_ways = 7'd4;
        touch(3, 1); touch(3, 2); touch(3, 3);
        @(negedge clk);
        touch_en = 1'b1; touch_set = 9'd3; touch_way = 6'd0;
        inv_en   = 1'b1; inv_set   = 9'd3; inv_way   = 6'd3;
        @(negedge clk);
        touch_en = 1'b0; inv_en = 1'b0;
        ref_touch(3, 0);
        check_victim(3, "R9 invalidate dropped");
    endtask

    // R10: sets are independent
    task automatic t_independent();
        cfg_ways = 7'd4;
        check_victim(5, "R10 untouched set stays empty");
        touch(5, 0); touch(5, 1);
        inval(5, 0);
        check_victim(1, "R10 other set unchanged");
        check_victim(3, "R10 other set unchanged 2");
    endtask

    // R11: full 64-way order under mixed traffic
    task automatic t_wide();
        logic [15:0] lfsr;
        cfg_ways = 7'd64;
        for (int i = 0; i < 64; i++) touch(0, (i * 37) % 64);
        check_victim(0, "R11 first of scrambled fill");
        lfsr = 16'hACE1;
        for (int k = 0; k < 240; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) inval(0, int'(lfsr[8:3]));
            else                   touch(0, int'(lfsr[9:4]));
            if (k % 12 == 11) check_victim(0, "R11 random order");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_ways = 7'd4;
        touch_en = 1'b0; inv_en = 1'b0; query_en = 1'b0;
        touch_set = '0; inv_set = '0; query_set = '0;
        touch_way = '0; inv_way = '0;
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 64; w++) begin
                ref_ts[s][w]  = 0;
                ref_vld[s][w] = 1'b0;
            end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_order();
        t_invalidate();
        t_range();
        t_same_cycle();
        t_collision();
        t_independent();
        t_wide();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule